// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the bus-facing register file of a simple serial port. A host reaches it through a word-indexed read/write bus with one-cycle read latency. It holds control and status words, a group of store-only configuration words (baud, FIFO control, millisecond tick), and a single-character receive holding slot. Writes to the transmit data word become byte strobes towards a serial engine. The engine offers received characters and line-break events through a valid/ready handshake.

The holding slot accepts one character at a time. A host read of the receive word consumes it, and the slot then accepts the next character. A single registered interrupt line is formed from the receive-ready and transmit-ready status bits and their enables. Writing the control2 word with its reset bit at zero restores every register to its reset value, with no reset pin involved. Bit-level serialization, baud generation, FIFOs and modem lines are outside this block.

Top module: `uart_regfile`

## Requirements
- R1: Registers are selected by word index: receive data 0x00, transmit data 0x10, control1 0x20, control2 0x21, control3 0x22, control4 0x23, FIFO control 0x24, status1 0x25, status2 0x26, baud increment 0x29, baud modulator 0x2A, baud count 0x2B, millisecond 0x2C, test 0x2D. Any other index reads zero, and writes to it change nothing. The test word is read-only.
- R2: After power-on reset the words read as follows: control1 0x0001 (enable bit 0), control2 0x0005 (reset bit 0 and transmit-enable bit 2), control3 0x0700, baud count 0x0004, status1 0x6040, status2 0x4028, test 0x0060 (TX-empty bit 6, RX-empty bit 5), receive data 0x4000 (error bit 14). All other stored words read 0. rx_ready is high and irq is low.
- R3: A read of the receive word returns the buffer. When RX-empty is clear, the read also sets bit 15 (character ready) in the returned value. It then clears status1 bit 9 (receive ready) and status2 bit 0 (data ready) and sets RX-empty. A read with RX-empty set changes nothing.
- R4: A character offered with rx_valid is taken only while rx_ready is high, and rx_ready equals the inverse of receive ready. Taking a character sets status1 bit 9 and status2 bit 0, clears RX-empty and loads the buffer with the zero-extended byte. A break event loads 0x0800 instead (break bit 11).
- R5: irq is registered, so it follows the state with one cycle of delay. The flag is formed from status1 AND control1, over bit 9 and bit 13 (transmit ready) only. Bit 13 counts only when control1 bit 6 (TX-empty enable) is set, and with that bit set the TX-empty flag is also ORed in.
- R6: Writing control2 with bit 0 at zero returns all registers, the buffer and the status words to their reset values, with control1 at 0. Control2 then holds the written low 16 bits with bit 0 forced to 1.
- R7: A status1 write clears only the written-one bits in mask 0x9DB0, and a status2 write clears only those in mask 0xBDD6. Receive ready, data ready, transmit ready and the other fixed status bits are not changed by such writes.
- R8: Writes to the control, FIFO-control, baud and millisecond words store the low 16 bits of the data.
- R9: A write to the transmit word gives a one-cycle tx_strobe with tx_byte equal to the low data byte on the next cycle, but only while control2 bit 2 is set. Otherwise the write is dropped.
- R10: bus_rdata and bus_rvalid are valid in the cycle after a read request, and they show the state as it was before that cycle's update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| bus_sel | input | 1 | Bus request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_idx | input | 6 | Word index (byte offset >> 2) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after request |
| bus_rvalid | output | 1 | Read data valid |
| rx_valid | input | 1 | Engine offers a character or break |
| rx_break | input | 1 | Offered item is a break event |
| rx_data | input | 8 | Offered character |
| rx_ready | output | 1 | Holding slot can take an item |
| tx_strobe | output | 1 | One-cycle transmit byte strobe |
| tx_byte | output | 8 | Transmit byte |
| irq | output | 1 | Registered level interrupt |

## Verification
The hardest situation to reach from the ports is the interrupt path, for three reasons: its output lags the state by a cycle, the TX-empty enable changes the meaning of the transmit-ready enable, and the receive-ready term comes and goes with each character handshake. The stimulus first fills the holding slot while the receive-ready enable is set. It checks irq in the cycle of acceptance and in the cycle after, then consumes the character by a bus read and checks that irq falls. It then walks control1 through the enable combinations, with and without TX-empty enable, so that each gating branch is seen. The soft reset is reached with a character still held, so the test shows it drops the buffered data as well as the registers.

// File: rtl/uart_regs_pkg.sv
// Package: word indices, bit positions, masks and reset values for the
// serial port register front end. Assumes a 16-bit register width.
package uart_regs_pkg;
    localparam int IDX_RXD   = 'h00;
    localparam int IDX_TXD   = 'h10;
    localparam int IDX_CTL1  = 'h20;
    localparam int IDX_CTL2  = 'h21;
    localparam int IDX_S1    = 'h25;
    localparam int IDX_S2    = 'h26;
    localparam int IDX_TEST  = 'h2D;

    localparam int B_RRDY    = 9;   // status1 receive ready / control1 enable
    localparam int B_TRDY    = 13;  // status1 transmit ready / control1 enable
    localparam int B_TXEEN   = 6;   // control1 TX-empty enable
    localparam int B_SRST    = 0;   // control2 soft reset (active low on write)
    localparam int B_TXEN    = 2;   // control2 transmitter enable
    localparam int B_RDR     = 0;   // status2 data ready
    localparam int B_TXE     = 6;   // test TX empty
    localparam int B_RXE     = 5;   // test RX empty
    localparam int B_CHRDY   = 15;  // receive word character ready

    localparam int S1_RESET  = 'h6040;
    localparam int S2_RESET  = 'h4028;
    localparam int S1_W1C    = 'h9DB0;
    localparam int S2_W1C    = 'hBDD6;
    localparam int RX_ERRVAL = 'h4000;
    localparam int RX_BRKVAL = 'h0800;
    localparam int CTL1_POR  = 'h0001;
    localparam int CTL2_POR  = 'h0005;

    localparam int NUM_PLAIN = 7;

    // Word index of each store-only register slot.
    function automatic int plain_idx(input int i);
        case (i)
            0: plain_idx = 'h22;  // control3
            1: plain_idx = 'h23;  // control4
            2: plain_idx = 'h24;  // FIFO control
            3: plain_idx = 'h29;  // baud increment
            4: plain_idx = 'h2A;  // baud modulator
            5: plain_idx = 'h2B;  // baud count
            default: plain_idx = 'h2C;  // millisecond
        endcase
    endfunction

    // Reset value of each store-only register slot.
    function automatic int plain_rst(input int i);
        case (i)
            0: plain_rst = 'h0700;
            5: plain_rst = 'h0004;
            default: plain_rst = 0;
        endcase
    endfunction
endpackage

// File: rtl/uart_rx_hold.sv
// One-character receive holding slot. Takes an item from the serial engine
// while empty; a consume request empties it. Assumes full and empty are
// never both requested to change in one cycle (guaranteed by the handshake).
module uart_rx_hold #(
    parameter int REG_W  = 16,
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              consume,
    input  logic              rx_valid,
    input  logic              rx_break,
    input  logic [CHAR_W-1:0] rx_data,
    output logic [REG_W-1:0]  rx_word,
    output logic              rx_full,
    output logic              rx_empty,
    output logic              rx_ready
);
    import uart_regs_pkg::*;

    logic [REG_W-1:0] buf_q;
    logic             full_q;
    logic             empty_q;

    // Load, consume or reset the holding slot.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            buf_q   <= REG_W'(RX_ERRVAL);
            full_q  <= 1'b0;
            empty_q <= 1'b1;
        end else if (consume && !empty_q) begin
            full_q  <= 1'b0;
            empty_q <= 1'b1;
        end else if (rx_valid && !full_q) begin
            full_q  <= 1'b1;
            empty_q <= 1'b0;
            buf_q   <= rx_break ? REG_W'(RX_BRKVAL) : REG_W'(rx_data);
        end
    end

    assign rx_word  = buf_q;
    assign rx_full  = full_q;
    assign rx_empty = empty_q;
    assign rx_ready = !full_q;

    AST_RX_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        full_q != empty_q);  // R3
    AST_RX_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && !consume && !soft_rst) |=> $stable(buf_q) && full_q);  // R4
endmodule

// File: rtl/uart_irq_gen.sv
// Registered interrupt from status1 and control1 enables, with the
// transmit-ready term gated by the TX-empty enable. Assumes status1 already
// carries the live receive-ready bit.
module uart_irq_gen #(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] ctl1,
    input  logic [REG_W-1:0] stat1,
    input  logic             tx_empty,
    output logic             irq
);
    import uart_regs_pkg::*;

    logic irq_d;
    logic irq_q;

    // Combine enabled status bits into the interrupt flag.
    always_comb begin
        irq_d = ctl1[B_RRDY] & stat1[B_RRDY];
        if (ctl1[B_TXEEN])
            irq_d = irq_d | (ctl1[B_TRDY] & stat1[B_TRDY]) | tx_empty;
    end

    // Register the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq = irq_q;

    AST_IRQ_NO_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl1[B_RRDY] && !ctl1[B_TXEEN]) |=> !irq_q);  // R5
endmodule

// File: rtl/uart_regfile.sv
// Serial port register front end: word-indexed bus, control/status words,
// store-only configuration words, receive slot and transmit strobe.
// Assumes one bus request per cycle and a synchronous active-low reset.
module uart_regfile #(
    parameter int IDX_W  = 6,
    parameter int BUS_W  = 32,
    parameter int REG_W  = 16,
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [IDX_W-1:0]  bus_idx,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              bus_rvalid,
    input  logic              rx_valid,
    input  logic              rx_break,
    input  logic [CHAR_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              tx_strobe,
    output logic [CHAR_W-1:0] tx_byte,
    output logic              irq
);
    import uart_regs_pkg::*;

    localparam int UPPER_W = BUS_W - REG_W;

    logic              wr, rd, soft_rst, consume;
    logic [REG_W-1:0]  wval;
    logic [REG_W-1:0]  ctl1_q, ctl2_q, s1_q, s2_q;
    logic [REG_W-1:0]  stat1, stat2, test_w, rx_word, rd_word;
    logic [REG_W-1:0]  plain_q [NUM_PLAIN];
    logic              rx_full, rx_empty;
    logic              tx_stb_q;
    logic [CHAR_W-1:0] tx_byte_q;
    logic [BUS_W-1:0]  rdata_q;
    logic              rvalid_q;
    logic              unused_hi;

    assign wr       = bus_sel && bus_we;
    assign rd       = bus_sel && !bus_we;
    assign wval     = bus_wdata[REG_W-1:0];
    assign unused_hi = ^bus_wdata[BUS_W-1:REG_W];
    assign soft_rst = wr && bus_idx == IDX_W'(IDX_CTL2) && !wval[B_SRST];
    assign consume  = rd && bus_idx == IDX_W'(IDX_RXD);

    // Control1 and control2 words with power-on and soft reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl1_q <= REG_W'(CTL1_POR);
            ctl2_q <= REG_W'(CTL2_POR);
        end else if (soft_rst) begin
            ctl1_q <= '0;
            ctl2_q <= wval | REG_W'(1 << B_SRST);
        end else if (wr && bus_idx == IDX_W'(IDX_CTL1)) begin
            ctl1_q <= wval;
        end else if (wr && bus_idx == IDX_W'(IDX_CTL2)) begin
            ctl2_q <= wval;
        end
    end

    // Store-only configuration words, one slot per index.
    for (genvar i = 0; i < NUM_PLAIN; i++) begin : g_plain
        always_ff @(posedge clk) begin
            if (!rst_n || soft_rst)
                plain_q[i] <= REG_W'(plain_rst(i));
            else if (wr && bus_idx == IDX_W'(plain_idx(i)))
                plain_q[i] <= wval;
        end
    end

    // Sticky status bits with write-one-to-clear on their masks.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            s1_q <= REG_W'(S1_RESET);
            s2_q <= REG_W'(S2_RESET);
        end else begin
            if (wr && bus_idx == IDX_W'(IDX_S1)) s1_q <= s1_q & ~(wval & REG_W'(S1_W1C));
            if (wr && bus_idx == IDX_W'(IDX_S2)) s2_q <= s2_q & ~(wval & REG_W'(S2_W1C));
        end
    end

    uart_rx_hold #(.REG_W(REG_W), .CHAR_W(CHAR_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .consume(consume),
        .rx_valid(rx_valid), .rx_break(rx_break), .rx_data(rx_data),
        .rx_word(rx_word), .rx_full(rx_full), .rx_empty(rx_empty),
        .rx_ready(rx_ready)
    );

    assign stat1  = s1_q | (REG_W'(rx_full) << B_RRDY);
    assign stat2  = s2_q | (REG_W'(rx_full) << B_RDR);
    assign test_w = (REG_W'(1'b1) << B_TXE) | (REG_W'(rx_empty) << B_RXE);

    uart_irq_gen #(.REG_W(REG_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .ctl1(ctl1_q), .stat1(stat1),
        .tx_empty(test_w[B_TXE]), .irq(irq)
    );

    // Select the word addressed by a read.
    always_comb begin
        rd_word = '0;
        case (bus_idx)
            IDX_W'(IDX_RXD):  rd_word = rx_word | (REG_W'(!rx_empty) << B_CHRDY);
            IDX_W'(IDX_CTL1): rd_word = ctl1_q;
            IDX_W'(IDX_CTL2): rd_word = ctl2_q;
            IDX_W'(IDX_S1):   rd_word = stat1;
            IDX_W'(IDX_S2):   rd_word = stat2;
            IDX_W'(IDX_TEST): rd_word = test_w;
            default: begin
                for (int i = 0; i < NUM_PLAIN; i++)
                    if (bus_idx == IDX_W'(plain_idx(i))) rd_word = plain_q[i];
            end
        endcase
    end

    // Register read data and valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= rd;
            if (rd) rdata_q <= {{UPPER_W{1'b0}}, rd_word};
        end
    end

    // Transmit strobe, gated by the transmitter enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_stb_q  <= 1'b0;
            tx_byte_q <= '0;
        end else begin
            tx_stb_q <= wr && bus_idx == IDX_W'(IDX_TXD) && ctl2_q[B_TXEN];
            if (wr && bus_idx == IDX_W'(IDX_TXD) && ctl2_q[B_TXEN])
                tx_byte_q <= wval[CHAR_W-1:0];
        end
    end

    assign bus_rdata  = rdata_q;
    assign bus_rvalid = rvalid_q;
    assign tx_strobe  = tx_stb_q;
    assign tx_byte    = tx_byte_q;

    AST_TX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stb_q |-> $past(ctl2_q[B_TXEN]));  // R9
    AST_SRST_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ctl2_q[B_SRST]);  // R6
    AST_RVALID_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rvalid_q) |-> $past(rd));  // R10
    AST_RX_CONSUME: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && rx_full && !soft_rst) |=> rx_empty && rx_ready);  // R3
endmodule

// File: tb/sim_uart_regfile.sv
// Bench for uart_regfile: table of write/readback vectors, then directed tests.
module sim_uart_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [5:0]  bus_idx = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        rx_valid = 1'b0, rx_break = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready, tx_strobe, irq;
    logic [7:0]  tx_byte;

    int nchk = 0, nfail = 0;
    logic        last_stb;
    logic [7:0]  last_byte;
    logic [31:0] rv;

    always #10 clk = ~clk;  // 50 MHz

    uart_regfile u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .rx_valid(rx_valid), .rx_break(rx_break),
        .rx_data(rx_data), .rx_ready(rx_ready), .tx_strobe(tx_strobe),
        .tx_byte(tx_byte), .irq(irq)
    );

    // {index, write data, expected readback}
    localparam logic [53:0] VEC [12] = '{
        {6'h22, 32'hABCD1234, 16'h1234},  // R8 control3
        {6'h23, 32'h0000BEEF, 16'hBEEF},  // R8 control4
        {6'h24, 32'hFFFF0A81, 16'h0A81},  // R8 FIFO control
        {6'h29, 32'h12345678, 16'h5678},  // R8 baud increment
        {6'h2A, 32'h00000F0F, 16'h0F0F},  // R8 baud modulator
        {6'h2B, 32'h80000022, 16'h0022},  // R8 baud count
        {6'h2C, 32'h000003E8, 16'h03E8},  // R8 millisecond
        {6'h30, 32'hFFFFFFFF, 16'h0000},  // R1 unmapped
        {6'h3F, 32'h00005555, 16'h0000},  // R1 unmapped
        {6'h2D, 32'h00000000, 16'h0060},  // R1 test word read-only
        {6'h25, 32'h0000FFFF, 16'h6040},  // R7 status1 fixed bits kept
        {6'h26, 32'h0000FFFF, 16'h4028}   // R7 status2 fixed bits kept
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [5:0] idx, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_idx = idx; bus_wdata = d;
        tick();
        last_stb = tx_strobe; last_byte = tx_byte;
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] idx, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_idx = idx;
        tick();
        d = bus_rdata;
        check("R10 rvalid", {31'b0, bus_rvalid}, 32'h1);
        bus_sel = 1'b0;
    endtask

    task automatic offer(input logic brk, input logic [7:0] d);
        rx_valid = 1'b1; rx_break = brk; rx_data = d;
        tick();
        rx_valid = 1'b0; rx_break = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        tick();
        // R2 reset state
        check("R2 irq", {31'b0, irq}, 32'h0);
        check("R2 rx_ready", {31'b0, rx_ready}, 32'h1);
        check("R10 rvalid idle", {31'b0, bus_rvalid}, 32'h0);
        bus_read(6'h20, rv); check("R2 control1", rv, 32'h0001);
        bus_read(6'h21, rv); check("R2 control2", rv, 32'h0005);
        bus_read(6'h22, rv); check("R2 control3", rv, 32'h0700);
        bus_read(6'h2B, rv); check("R2 baud count", rv, 32'h0004);
        bus_read(6'h25, rv); check("R2 status1", rv, 32'h6040);
        bus_read(6'h26, rv); check("R2 status2", rv, 32'h4028);
        bus_read(6'h2D, rv); check("R2 test", rv, 32'h0060);
        bus_read(6'h00, rv); check("R2 receive word", rv, 32'h4000);

        // Vector table: write then read back
        foreach (VEC[i]) begin
            bus_write(VEC[i][53:48], VEC[i][47:16]);
            bus_read(VEC[i][53:48], rv);
            check("R1/R7/R8 vector", rv, {16'b0, VEC[i][15:0]});
        end

        // R9 transmit
        bus_write(6'h10, 32'h000001A5);
        check("R9 strobe enabled", {31'b0, last_stb}, 32'h1);
        check("R9 byte", {24'b0, last_byte}, 32'hA5);
        tick();
        check("R9 strobe one cycle", {31'b0, tx_strobe}, 32'h0);
        bus_write(6'h21, 32'h00000001);
        bus_write(6'h10, 32'h0000003C);
        check("R9 strobe disabled", {31'b0, last_stb}, 32'h0);

        // R4 / R3 receive path
        offer(1'b0, 8'h41);
        check("R4 rx_ready low", {31'b0, rx_ready}, 32'h0);
        offer(1'b0, 8'h42);  // must be refused
        bus_read(6'h25, rv); check("R4 status1 rrdy", rv, 32'h6240);
        bus_read(6'h26, rv); check("R4 status2 rdr", rv, 32'h4029);
        bus_read(6'h2D, rv); check("R4 test rx not empty", rv, 32'h0040);
        bus_write(6'h25, 32'h0000FFFF);
        bus_write(6'h26, 32'h0000FFFF);
        bus_read(6'h25, rv); check("R7 status1 rrdy kept", rv, 32'h6240);
        bus_read(6'h26, rv); check("R7 status2 rdr kept", rv, 32'h4029);
        bus_read(6'h00, rv); check("R3 first read", rv, 32'h8041);
        check("R4 rx_ready back", {31'b0, rx_ready}, 32'h1);
        bus_read(6'h25, rv); check("R3 status1 cleared", rv, 32'h6040);
        bus_read(6'h26, rv); check("R3 status2 cleared", rv, 32'h4028);
        bus_read(6'h2D, rv); check("R3 test empty", rv, 32'h0060);
        bus_read(6'h00, rv); check("R3 second read", rv, 32'h0041);
        offer(1'b1, 8'h00);
        bus_read(6'h00, rv); check("R4 break value", rv, 32'h8800);

        // R5 interrupt
        bus_write(6'h20, 32'h00000201);
        tick(); check("R5 enabled idle", {31'b0, irq}, 32'h0);
        offer(1'b0, 8'h5A);
        check("R5 lag", {31'b0, irq}, 32'h0);
        tick(); check("R5 rx irq", {31'b0, irq}, 32'h1);
        bus_read(6'h00, rv); check("R3 read for irq", rv, 32'h805A);
        tick(); check("R5 irq drop", {31'b0, irq}, 32'h0);
        bus_write(6'h20, 32'h00002001);
        tick(); check("R5 trdy masked", {31'b0, irq}, 32'h0);
        bus_write(6'h20, 32'h00002041);
        check("R5 trdy lag", {31'b0, irq}, 32'h0);
        tick(); check("R5 trdy unmasked", {31'b0, irq}, 32'h1);
        bus_write(6'h20, 32'h00000041);
        tick(); check("R5 tx empty term", {31'b0, irq}, 32'h1);
        bus_write(6'h20, 32'h00000001);
        tick(); check("R5 all off", {31'b0, irq}, 32'h0);

        // R6 soft reset with a character held
        bus_write(6'h22, 32'h00001234);
        bus_write(6'h20, 32'h00000201);
        offer(1'b0, 8'h77);
        bus_write(6'h21, 32'h00000006);
        bus_read(6'h21, rv); check("R6 control2", rv, 32'h0007);
        bus_read(6'h20, rv); check("R6 control1", rv, 32'h0000);
        bus_read(6'h22, rv); check("R6 control3", rv, 32'h0700);
        bus_read(6'h2B, rv); check("R6 baud count", rv, 32'h0004);
        bus_read(6'h2D, rv); check("R6 test", rv, 32'h0060);
        bus_read(6'h00, rv); check("R6 receive word", rv, 32'h4000);
        check("R6 rx_ready", {31'b0, rx_ready}, 32'h1);
        check("R6 irq", {31'b0, irq}, 32'h0);

        summary();
        $finish;
    end
endmodule